// File: doc/BRIEF.md
# Processor Interrupt Recognition Logic

This block sits on the core side of an interrupt path and decides when the processor stops normal execution to service an interrupt. The interrupt controller presents a 3-bit encoded request level (0 = no request, 7 = highest). The core presents a strobe that marks each instruction boundary, which is the only moment at which a pending request can be recognised. The block keeps the 16-bit status word, whose 3-bit interrupt mask field sits in bits 10:8. A status write port lets the core load the whole word.

Requests at levels 1 to 6 are level-sensitive and maskable. They are taken at a boundary only if the level is still present and is strictly above the mask. Level 7 cannot be masked and is edge-triggered. A rising transition into level 7 is caught even between boundaries and held until the next boundary services it. A level 7 that stays asserted is serviced only once. On recognition the block emits a one-clock take pulse with the serviced level and raises the mask to that level.

Top module: `irq_recog_core`

## Requirements
- R1: After reset the status word reads 16'h0700 (mask field 7, all other bits 0) and take_o is low.
- R2: An interrupt is recognised only in a cycle where boundary_i is high. Requests held between boundaries produce no take pulse.
- R3: At a boundary, a request level L in 1..6 is taken when L is greater than the mask field. It is not taken when L is equal to or below the mask.
- R4: Levels 1..6 are level-sensitive. A request that went away before the boundary cycle is not taken.
- R5: A transition of the request level into 7 is taken at a boundary regardless of the mask, including a mask of 7.
- R6: A level-7 request held continuously is taken only once. The level must fall below 7 and rise again to be taken again.
- R7: A level-7 transition that occurs between boundaries is latched and taken at the next boundary, even if the request has since fallen. After it is serviced the latch is cleared.
- R8: When a latched level-7 event and a maskable request are both pending at a boundary, level 7 is taken.
- R9: A recognition at the boundary sampled on clock edge N drives take_o high for exactly the cycle after edge N. In that cycle take_lvl_o holds the serviced level and the mask field equals that level.
- R10: A status write (sr_we_i) loads all 16 bits at the next edge. If a recognition happens on the same edge, the mask field takes the serviced level and the other bits take the written value.
- R11: The mask field occupies bits 10:8 of the status word. The compare in R3 uses exactly those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_lvl_i | input | 3 | Encoded interrupt request level, 0 = none |
| boundary_i | input | 1 | Instruction-boundary strobe |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | 16 | Status word write data |
| sr_o | output | 16 | Current status word, mask in bits 10:8 |
| take_o | output | 1 | One-cycle interrupt recognition pulse |
| take_lvl_o | output | 3 | Level being serviced, valid with take_o |

## Verification
The hardest case to reach is a level-7 event that must survive between boundaries. A short pulse to 7 has to be caught, held while the request has already fallen to a lower or zero level, and then serviced ahead of a live maskable request. The directed stimulus builds this by raising the request to 7 for a single cycle with the boundary strobe low, then dropping it to a maskable level before strobing the boundary. A separate scenario holds 7 across several boundaries with the mask open, to show that the latch does not rearm without a fall below 7. A further case strobes the boundary on the same edge as a status write, to check how the mask field and the written bits are merged.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;
  localparam int unsigned IRQ_LVL_W = 3;
  localparam logic [IRQ_LVL_W-1:0] IRQ_LVL_NMI  = {IRQ_LVL_W{1'b1}};
  localparam logic [IRQ_LVL_W-1:0] IRQ_LVL_NONE = '0;

  typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;

  typedef struct packed {
    logic     take;
    irq_lvl_t lvl;
  } irq_decision_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
  import irq_recog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_lvl_t req_lvl,
  input  logic     clr,
  output logic     pend
);
  irq_lvl_t prev_q;
  logic     pend_q;
  logic     edge_now;
  logic     pend_d;
  logic     pend_en;

  // A transition into the top level, seen this cycle
  always_comb begin
    edge_now = (req_lvl == IRQ_LVL_NMI) && (prev_q != IRQ_LVL_NMI);
    pend     = pend_q | edge_now;
    pend_en  = edge_now | clr;
    pend_d   = clr ? 1'b0 : pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IRQ_LVL_NONE;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req_lvl;
      if (pend_en) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_recog_pkg::*;
(
  input  irq_lvl_t      req_lvl,
  input  irq_lvl_t      mask,
  input  logic          nmi_pend,
  input  logic          boundary,
  output irq_decision_t dec
);
  always_comb begin
    dec.take = 1'b0;
    dec.lvl  = IRQ_LVL_NONE;
    if (boundary) begin
      if (nmi_pend) begin
        dec.take = 1'b1;
        dec.lvl  = IRQ_LVL_NMI;
      end else if ((req_lvl != IRQ_LVL_NMI) && (req_lvl > mask)) begin
        dec.take = 1'b1;
        dec.lvl  = req_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_recog_core.sv
module irq_recog_core
  import irq_recog_pkg::*;
#(
  parameter int unsigned SR_W        = 16,
  parameter int unsigned MASK_LSB    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LVL_W-1:0] req_lvl_i,
  input  logic                 boundary_i,
  input  logic                 sr_we_i,
  input  logic [SR_W-1:0]      sr_wdata_i,
  output logic [SR_W-1:0]      sr_o,
  output logic                 take_o,
  output logic [IRQ_LVL_W-1:0] take_lvl_o
);
  localparam logic [SR_W-1:0] SR_RST = SR_W'({IRQ_LVL_W{1'b1}}) << MASK_LSB;

  logic          rst_s_n;
  logic          nmi_pend;
  irq_decision_t dec;
  irq_lvl_t      mask;

  logic [SR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic            take_q;
  irq_lvl_t        tlvl_q;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign mask = sr_q[MASK_LSB +: IRQ_LVL_W];

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_s_n), .req_lvl(req_lvl_i),
    .clr(dec.take && (dec.lvl == IRQ_LVL_NMI)), .pend(nmi_pend)
  );

  irq_select u_sel (
    .req_lvl(req_lvl_i), .mask(mask), .nmi_pend(nmi_pend),
    .boundary(boundary_i), .dec(dec)
  );

  // Next state of the status word: write first, recognition overrides mask
  always_comb begin
    sr_en = sr_we_i | dec.take;
    sr_d  = sr_we_i ? sr_wdata_i : sr_q;
    if (dec.take) sr_d[MASK_LSB +: IRQ_LVL_W] = dec.lvl;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sr_q   <= SR_RST;
      take_q <= 1'b0;
      tlvl_q <= IRQ_LVL_NONE;
    end else begin
      if (sr_en) sr_q <= sr_d;
      take_q <= dec.take;
      tlvl_q <= dec.lvl;
    end
  end

  assign sr_o       = sr_q;
  assign take_o     = take_q;
  assign take_lvl_o = tlvl_q;
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk
  import irq_recog_pkg::*;
#(
  parameter int unsigned SR_W     = 16,
  parameter int unsigned MASK_LSB = 8
) (
  input logic                 clk,
  input logic                 rst_s_n,
  input logic [IRQ_LVL_W-1:0] req_lvl_i,
  input logic                 boundary_i,
  input logic                 sr_we_i,
  input logic [SR_W-1:0]      sr_wdata_i,
  input logic [SR_W-1:0]      sr_o,
  input logic                 take_o,
  input logic [IRQ_LVL_W-1:0] take_lvl_o
);
  p_boundary_only_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    take_o |-> $past(boundary_i));

  p_mask_follows_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    take_o |-> (sr_o[MASK_LSB +: IRQ_LVL_W] == take_lvl_o));

  p_level_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    take_o |-> (take_lvl_o != IRQ_LVL_NONE));

  // R3 / R11: a maskable take must beat the previous mask field
  p_mask_compare_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_o && take_lvl_o != IRQ_LVL_NMI) |->
      (take_lvl_o == $past(req_lvl_i)) &&
      ($past(req_lvl_i) > $past(sr_o[MASK_LSB +: IRQ_LVL_W])));

  p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!take_o && $past(sr_we_i)) |-> (sr_o == $past(sr_wdata_i)));

  p_sr_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!take_o && !$past(sr_we_i)) |-> $stable(sr_o));
endmodule

bind irq_recog_core irq_recog_chk #(.SR_W(SR_W), .MASK_LSB(MASK_LSB)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .req_lvl_i(req_lvl_i), .boundary_i(boundary_i),
  .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .sr_o(sr_o),
  .take_o(take_o), .take_lvl_o(take_lvl_o)
);

// File: tb/irq_recog_core_test.sv
`timescale 1ns/1ps
module irq_recog_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req_lvl_i;
  logic        boundary_i;
  logic        sr_we_i;
  logic [15:0] sr_wdata_i;
  logic [15:0] sr_o;
  logic        take_o;
  logic [2:0]  take_lvl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_recog_core uut (
    .clk(clk), .rst_n(rst_n), .req_lvl_i(req_lvl_i), .boundary_i(boundary_i),
    .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .sr_o(sr_o),
    .take_o(take_o), .take_lvl_o(take_lvl_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_sr(logic [15:0] v);
    sr_we_i = 1'b1; sr_wdata_i = v;
    step();
    sr_we_i = 1'b0;
  endtask

  // Strobe a boundary for one edge, then check the registered take outputs
  task automatic strobe(string req, logic exp_take, logic [2:0] exp_lvl);
    boundary_i = 1'b1;
    step();
    boundary_i = 1'b0;
    check(req, {15'd0, take_o}, {15'd0, exp_take});
    if (exp_take) check(req, {13'd0, take_lvl_o}, {13'd0, exp_lvl});
  endtask

  task automatic t_reset();
    check("R1", sr_o, 16'h0700);
    check("R1", {15'd0, take_o}, 16'd0);
  endtask

  task automatic t_mask();
    write_sr(16'h0300);
    check("R11", sr_o, 16'h0300);
    req_lvl_i = 3'd3;
    strobe("R3", 1'b0, 3'd0);
    req_lvl_i = 3'd4;
    step(3);
    check("R2", {15'd0, take_o}, 16'd0);
    strobe("R3", 1'b1, 3'd4);
    check("R9", sr_o, 16'h0400);
    step();
    check("R9", {15'd0, take_o}, 16'd0);
    req_lvl_i = 3'd2;
    strobe("R3", 1'b0, 3'd0);
    req_lvl_i = 3'd0;
  endtask

  task automatic t_level();
    write_sr(16'h0000);
    req_lvl_i = 3'd5;
    step();
    req_lvl_i = 3'd0;
    step();
    strobe("R4", 1'b0, 3'd0);
    check("R4", sr_o, 16'h0000);
  endtask

  task automatic t_nmi();
    write_sr(16'h2700);
    req_lvl_i = 3'd7;
    strobe("R5", 1'b1, 3'd7);
    check("R5", sr_o, 16'h2700);
    write_sr(16'h0000);
    strobe("R6", 1'b0, 3'd0);
    step(2);
    strobe("R6", 1'b0, 3'd0);
    req_lvl_i = 3'd0;
    step();
    req_lvl_i = 3'd7;
    step();
    req_lvl_i = 3'd0;
    step(2);
    strobe("R7", 1'b1, 3'd7);
    write_sr(16'h0000);
    strobe("R7", 1'b0, 3'd0);
  endtask

  task automatic t_prio();
    write_sr(16'h0000);
    req_lvl_i = 3'd7;
    step();
    req_lvl_i = 3'd5;
    step();
    strobe("R8", 1'b1, 3'd7);
    strobe("R8", 1'b0, 3'd0);
    write_sr(16'h0000);
    strobe("R8", 1'b1, 3'd5);
    req_lvl_i = 3'd0;
  endtask

  task automatic t_collide();
    write_sr(16'h0000);
    req_lvl_i = 3'd3;
    sr_we_i = 1'b1; sr_wdata_i = 16'h2100;
    strobe("R10", 1'b1, 3'd3);
    sr_we_i = 1'b0;
    check("R10", sr_o, 16'h2300);
    write_sr(16'h0500);
    req_lvl_i = 3'd5;
    strobe("R11", 1'b0, 3'd0);
    req_lvl_i = 3'd6;
    strobe("R11", 1'b1, 3'd6);
    check("R10", sr_o, 16'h0600);
    req_lvl_i = 3'd0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_lvl_i = 3'd0; boundary_i = 1'b0;
    sr_we_i = 1'b0; sr_wdata_i = 16'h0000;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_mask();
    t_level();
    t_nmi();
    t_prio();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule